// File: doc/BRIEF.md
# Bus-Based Microcoded Datapath

This block is the register-and-ALU half of a microprogrammed processor. In every cycle a controller supplies a source code for the B bus, a vector of destination enables for the C bus, six ALU control bits and two shifter control bits. One register is placed on the B bus. The ALU combines it with the holding register H, which is always its A operand. The shifter then reshapes the ALU output, and the result on the C bus is captured by every enabled destination at the next rising clock edge.

The memory-facing registers are visible on ports. These are the word address register, the word data register, the program counter and the 8-bit byte buffer. An external memory controller can therefore read them and return fetched data. Returned data arrives on two valid-qualified inputs, one for the 32-bit data register and one for the byte buffer. Both are accepted in any cycle in which valid is high. There is no ready signal, so the controller never sees back-pressure and must not present data it cannot afford to have captured. The N and Z flags are produced combinationally in the same cycle, ready for a sequencer to register.

Top module: `mc_datapath`

## Requirements
- R1: With `rst_n` low at a rising edge, every register becomes zero. This covers H, OPC, TOS, CPP, LV, SP, PC, MDR, MAR and the byte buffer.
- R2: `bsel` places one source on the B bus: 0 MDR, 1 PC, 2 byte buffer sign-extended, 3 byte buffer zero-extended, 4 SP, 5 LV, 6 CPP, 7 TOS, 8 OPC. Codes 9 to 15 place zero on the bus. MAR and H are never B sources.
- R3: `cwe` bit 8..0 enables H, OPC, TOS, CPP, LV, SP, PC, MDR, MAR respectively. Any combination may be set. Every enabled register takes the C bus value at the next rising edge, and registers with a clear bit keep their value.
- R4: `alu_ctl` = {f0,f1,ena,enb,inva,inc}. A is H gated by ena, then inverted if inva. B is the bus gated by enb. The function f0f1 is: 00 gives A AND B, 01 gives A OR B, 10 gives NOT B, 11 gives A+B+inc, modulo 2^32.
- R5: `flag_n` equals bit 31 of the ALU output and `flag_z` is high exactly when the ALU output is zero. Both are taken before the shifter, in the same cycle.
- R6: The sign-extended byte source copies byte bit 7 into bits 31..8, and the zero-extended source fills bits 31..8 with zero.
- R7: `shf_ctl` selects the shifter mode: 00 passes the value through, 01 shifts left logically by 8, 10 shifts right arithmetically by 1, and 11 passes the value through.
- R8: When `mdr_in_valid` is high, MDR takes `mdr_din` at the next edge, even if `cwe` bit 1 is set in the same cycle. When `mbr_in_valid` is high, the byte buffer takes `mbr_din`. Otherwise the byte buffer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bsel | input | 4 | B bus source code |
| cwe | input | 9 | C bus destination enables |
| alu_ctl | input | 6 | ALU function controls |
| shf_ctl | input | 2 | Shifter mode |
| mdr_in_valid | input | 1 | Memory data word valid |
| mdr_din | input | 32 | Memory data word |
| mbr_in_valid | input | 1 | Fetched byte valid |
| mbr_din | input | 8 | Fetched byte |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Word data register |
| pc_q | output | 32 | Program counter |
| mbr_q | output | 8 | Byte buffer |
| cbus_o | output | 32 | Current C bus value |
| flag_n | output | 1 | ALU result negative |
| flag_z | output | 1 | ALU result zero |

## Verification
The assertions take for granted that all control and data inputs are known and hold steady between rising edges. They also assume that a memory word and a C bus write to MDR may coincide, with the memory word winning. The stimulus drives every input just after the falling edge and never changes it before the next rising edge. It draws all 16 select codes, all nine-bit enable patterns, every ALU and shifter code and random valid strobes, so overlaps occur often but never break those assumptions.

// File: rtl/dp_pkg.sv
package dp_pkg;
  parameter int unsigned DW   = 32;
  parameter int unsigned BW   = 8;
  parameter int unsigned SELW = 4;
  parameter int unsigned NCW  = 9;
  localparam int unsigned NSRC = 1 << SELW;

  typedef enum logic [SELW-1:0] {
    B_MDR  = 4'd0,
    B_PC   = 4'd1,
    B_MBRS = 4'd2,
    B_MBRU = 4'd3,
    B_SP   = 4'd4,
    B_LV   = 4'd5,
    B_CPP  = 4'd6,
    B_TOS  = 4'd7,
    B_OPC  = 4'd8
  } bsrc_e;

  localparam int unsigned C_MAR = 0;
  localparam int unsigned C_MDR = 1;
  localparam int unsigned C_PC  = 2;
  localparam int unsigned C_SP  = 3;
  localparam int unsigned C_LV  = 4;
  localparam int unsigned C_CPP = 5;
  localparam int unsigned C_TOS = 6;
  localparam int unsigned C_OPC = 7;
  localparam int unsigned C_H   = 8;

  typedef enum logic [1:0] {
    SH_PASS = 2'b00,
    SH_SLL8 = 2'b01,
    SH_SRA1 = 2'b10,
    SH_KEEP = 2'b11
  } shf_e;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic         alt_we,
  input  logic [W-1:0] alt_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (alt_we) q <= alt_d;
    else if (we)     q <= d;
  end
endmodule

// File: rtl/dp_bmux.sv
module dp_bmux #(
  parameter int unsigned W    = 32,
  parameter int unsigned SELW = 4,
  localparam int unsigned N   = 1 << SELW
) (
  input  logic [SELW-1:0] sel,
  input  logic [W-1:0]    src [N],
  output logic [W-1:0]    bus
);
  logic [N-1:0] sel_oh;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign sel_oh[i] = (sel == SELW'(i));
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      bus = bus | (src[i] & {W{sel_oh[i]}});
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned W = 32
) (
  input  logic [5:0]   ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         neg,
  output logic         zero
);
  logic         f0, f1, en_a, en_b, inv_a, cin;
  logic [W-1:0] opa, opb;

  assign {f0, f1, en_a, en_b, inv_a, cin} = ctl;
  assign opa = (en_a ? a : '0) ^ {W{inv_a}};
  assign opb = en_b ? b : '0;

  always_comb begin
    unique case ({f0, f1})
      2'b00:   y = opa & opb;
      2'b01:   y = opa | opb;
      2'b10:   y = ~opb;
      default: y = opa + opb + W'(cin);
    endcase
  end

  assign neg  = y[W-1];
  assign zero = (y == '0);
endmodule

// File: rtl/dp_shift.sv
module dp_shift #(
  parameter int unsigned W = 32,
  parameter int unsigned BW = 8
) (
  input  dp_pkg::shf_e mode,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (mode)
      dp_pkg::SH_SLL8: y = {x[W-BW-1:0], {BW{1'b0}}};
      dp_pkg::SH_SRA1: y = {x[W-1], x[W-1:1]};
      default:         y = x;
    endcase
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import dp_pkg::*;
#(
  parameter int unsigned W   = dp_pkg::DW,
  parameter int unsigned BYW = dp_pkg::BW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SELW-1:0]      bsel,
  input  logic [NCW-1:0]       cwe,
  input  logic [5:0]           alu_ctl,
  input  logic [1:0]           shf_ctl,
  input  logic                 mdr_in_valid,
  input  logic [W-1:0]         mdr_din,
  input  logic                 mbr_in_valid,
  input  logic [BYW-1:0]       mbr_din,
  output logic [W-1:0]         mar_q,
  output logic [W-1:0]         mdr_q,
  output logic [W-1:0]         pc_q,
  output logic [BYW-1:0]       mbr_q,
  output logic [W-1:0]         cbus_o,
  output logic                 flag_n,
  output logic                 flag_z
);
  logic [W-1:0] rq  [NCW];
  logic [W-1:0] src [NSRC];
  logic [W-1:0] bbus, alu_y, cbus;
  logic [BYW-1:0] mbr;

  // Register set: one cell per C enable bit; only MDR has a memory port.
  for (genvar k = 0; k < NCW; k++) begin : g_reg
    if (k == C_MDR) begin : g_mem
      dp_reg #(.W(W)) u_r (
        .clk(clk), .rst_n(rst_n), .we(cwe[k]), .d(cbus),
        .alt_we(mdr_in_valid), .alt_d(mdr_din), .q(rq[k]));
    end else begin : g_plain
      dp_reg #(.W(W)) u_r (
        .clk(clk), .rst_n(rst_n), .we(cwe[k]), .d(cbus),
        .alt_we(1'b0), .alt_d('0), .q(rq[k]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            mbr <= '0;
    else if (mbr_in_valid) mbr <= mbr_din;
  end

  // B bus sources; unused codes read as zero.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == B_MDR)       begin : g0 assign src[i] = rq[C_MDR]; end
    else if (i == B_PC)   begin : g1 assign src[i] = rq[C_PC]; end
    else if (i == B_MBRS) begin : g2 assign src[i] = {{(W-BYW){mbr[BYW-1]}}, mbr}; end
    else if (i == B_MBRU) begin : g3 assign src[i] = {{(W-BYW){1'b0}}, mbr}; end
    else if (i == B_SP)   begin : g4 assign src[i] = rq[C_SP]; end
    else if (i == B_LV)   begin : g5 assign src[i] = rq[C_LV]; end
    else if (i == B_CPP)  begin : g6 assign src[i] = rq[C_CPP]; end
    else if (i == B_TOS)  begin : g7 assign src[i] = rq[C_TOS]; end
    else if (i == B_OPC)  begin : g8 assign src[i] = rq[C_OPC]; end
    else                  begin : gz assign src[i] = '0; end
  end

  dp_bmux #(.W(W), .SELW(SELW)) u_bmux (
    .sel(bsel), .src(src), .bus(bbus));

  dp_alu #(.W(W)) u_alu (
    .ctl(alu_ctl), .a(rq[C_H]), .b(bbus),
    .y(alu_y), .neg(flag_n), .zero(flag_z));

  dp_shift #(.W(W), .BW(BYW)) u_shf (
    .mode(shf_e'(shf_ctl)), .x(alu_y), .y(cbus));

  assign cbus_o = cbus;
  assign mar_q  = rq[C_MAR];
  assign mdr_q  = rq[C_MDR];
  assign pc_q   = rq[C_PC];
  assign mbr_q  = mbr;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int unsigned W = 32,
  parameter int unsigned BYW = 8,
  parameter int unsigned NC = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NC-1:0]  cwe,
  input logic [1:0]     shf_ctl,
  input logic           mdr_in_valid,
  input logic [W-1:0]   mdr_din,
  input logic           mbr_in_valid,
  input logic [BYW-1:0] mbr_din,
  input logic [W-1:0]   mar_q,
  input logic [W-1:0]   mdr_q,
  input logic [W-1:0]   pc_q,
  input logic [BYW-1:0] mbr_q,
  input logic [W-1:0]   cbus_o,
  input logic           flag_n,
  input logic           flag_z
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (mar_q == '0 && mdr_q == '0 && pc_q == '0 && mbr_q == '0));

  p_mar_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cwe[0] |=> mar_q == $past(cbus_o));

  p_mar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cwe[0] |=> $stable(mar_q));

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cwe[2] |=> $stable(pc_q));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shf_ctl == 2'b00 |-> flag_z == (cbus_o == '0));

  p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shf_ctl == 2'b00 |-> flag_n == cbus_o[W-1]);

  p_mdr_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_in_valid |=> mdr_q == $past(mdr_din));

  p_mbr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_in_valid |=> mbr_q == $past(mbr_din));

  p_mbr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mbr_in_valid |=> $stable(mbr_q));
endmodule

bind mc_datapath dp_checker #(.W(W), .BYW(BYW), .NC(dp_pkg::NCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cwe(cwe), .shf_ctl(shf_ctl),
  .mdr_in_valid(mdr_in_valid), .mdr_din(mdr_din),
  .mbr_in_valid(mbr_in_valid), .mbr_din(mbr_din),
  .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q),
  .cbus_o(cbus_o), .flag_n(flag_n), .flag_z(flag_z));

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
  localparam int PERIOD = 10;
  localparam logic [5:0] PASS_B = 6'b110100;
  localparam logic [5:0] PASS_H = 6'b111000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bsel = '0;
  logic [8:0]  cwe = '0;
  logic [5:0]  alu_ctl = '0;
  logic [1:0]  shf_ctl = '0;
  logic        mdr_in_valid = 1'b0;
  logic [31:0] mdr_din = '0;
  logic        mbr_in_valid = 1'b0;
  logic [7:0]  mbr_din = '0;
  logic [31:0] mar_q, mdr_q, pc_q, cbus_o;
  logic [7:0]  mbr_q;
  logic        flag_n, flag_z;

  int total = 0;
  int bad = 0;
  logic [31:0] m [9];
  logic [7:0]  mm;

  always #(PERIOD/2) clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n), .bsel(bsel), .cwe(cwe), .alu_ctl(alu_ctl),
    .shf_ctl(shf_ctl), .mdr_in_valid(mdr_in_valid), .mdr_din(mdr_din),
    .mbr_in_valid(mbr_in_valid), .mbr_din(mbr_din), .mar_q(mar_q),
    .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q), .cbus_o(cbus_o),
    .flag_n(flag_n), .flag_z(flag_z));

  function automatic logic [31:0] ref_b(input logic [3:0] s);
    case (s)
      4'd0: return m[1];
      4'd1: return m[2];
      4'd2: return {{24{mm[7]}}, mm};
      4'd3: return {24'h0, mm};
      4'd4: return m[3];
      4'd5: return m[4];
      4'd6: return m[5];
      4'd7: return m[6];
      4'd8: return m[7];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] c, input logic [31:0] h, input logic [31:0] b);
    logic [31:0] a, bb;
    a  = c[3] ? h : 32'h0;
    if (c[1]) a = ~a;
    bb = c[2] ? b : 32'h0;
    case (c[5:4])
      2'b00: return a & bb;
      2'b01: return a | bb;
      2'b10: return ~bb;
      default: return a + bb + {31'h0, c[0]};
    endcase
  endfunction

  function automatic logic [31:0] ref_shf(input logic [1:0] s, input logic [31:0] x);
    case (s)
      2'b01: return x << 8;
      2'b10: return {x[31], x[31:1]};
      default: return x;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] bs, input logic [8:0] cw, input logic [5:0] ac,
                      input logic [1:0] sc, input logic mv, input logic [31:0] md,
                      input logic bv, input logic [7:0] bd);
    logic [31:0] ey, ec;
    logic [31:0] nm [9];
    @(negedge clk);
    bsel = bs; cwe = cw; alu_ctl = ac; shf_ctl = sc;
    mdr_in_valid = mv; mdr_din = md; mbr_in_valid = bv; mbr_din = bd;
    ey = ref_alu(ac, m[8], ref_b(bs));
    ec = ref_shf(sc, ey);
    #(PERIOD/4);
    chk("R2 R4 R6 R7 cbus", cbus_o, ec);
    chk("R5 flag_n", {31'h0, flag_n}, {31'h0, ey[31]});
    chk("R5 flag_z", {31'h0, flag_z}, {31'h0, (ey == 32'h0)});
    for (int k = 0; k < 9; k++) begin
      nm[k] = m[k];
      if (k == 1 && mv) nm[k] = md;
      else if (cw[k]) nm[k] = ec;
    end
    @(posedge clk);
    for (int k = 0; k < 9; k++) m[k] = nm[k];
    if (bv) mm = bd;
    #1;
    chk("R3 mar", mar_q, m[0]);
    chk("R3 R8 mdr", mdr_q, m[1]);
    chk("R3 pc", pc_q, m[2]);
    chk("R8 mbr", {24'h0, mbr_q}, {24'h0, mm});
  endtask

  // place a value into every register selected by cw, via MDR
  task automatic put(input logic [8:0] cw, input logic [31:0] v);
    step(4'd0, 9'h0, PASS_B, 2'b00, 1'b1, v, 1'b0, 8'h0);
    step(4'd0, cw, PASS_B, 2'b00, 1'b0, 32'h0, 1'b0, 8'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'd20061220;
    r = $urandom(seed);
    for (int k = 0; k < 9; k++) m[k] = 32'h0;
    mm = 8'h0;
    // R1: reset clears everything
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mar reset", mar_q, 32'h0);
    chk("R1 mdr reset", mdr_q, 32'h0);
    chk("R1 pc reset", pc_q, 32'h0);
    chk("R1 mbr reset", {24'h0, mbr_q}, 32'h0);
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) step(4'(s), 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
    step(4'd0, 9'h0, PASS_H, 2'b00, 1'b0, 0, 1'b0, 0);

    // R3: distinct values in every register, multi-destination write
    put(9'h1FF, 32'hA5A5_0F0F);
    for (int k = 0; k < 9; k++) put(9'(1 << k), 32'h1000_0001 * (k + 1));
    step(4'd0, 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b1, 8'h9C);
    // R2: each code reads its own source; 9..15 yield zero
    for (int s = 0; s < 16; s++) begin
      step(4'(s), 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
      if (s >= 9) chk("R2 unused code zero", cbus_o, 32'h0);
    end
    // R6: byte extension both ways
    step(4'd2, 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
    chk("R6 sign extend", cbus_o, 32'hFFFF_FF9C);
    step(4'd3, 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
    chk("R6 zero extend", cbus_o, 32'h0000_009C);
    // R5: zero and negative corners
    put(9'h100, 32'h0000_0001);
    put(9'h002, 32'hFFFF_FFFF);
    step(4'd0, 9'h0, 6'b111100, 2'b00, 1'b0, 0, 1'b0, 0);
    chk("R5 sum wraps to zero", {31'h0, flag_z}, 32'h1);
    step(4'd0, 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
    chk("R5 negative", {31'h0, flag_n}, 32'h1);
    // R7: shifter on negative value
    step(4'd0, 9'h0, PASS_B, 2'b10, 1'b0, 0, 1'b0, 0);
    chk("R7 sra1", cbus_o, 32'hFFFF_FFFF);
    put(9'h002, 32'h8123_4567);
    step(4'd0, 9'h0, PASS_B, 2'b01, 1'b0, 0, 1'b0, 0);
    chk("R7 sll8", cbus_o, 32'h2345_6700);
    step(4'd0, 9'h0, PASS_B, 2'b11, 1'b0, 0, 1'b0, 0);
    chk("R7 mode 3 pass", cbus_o, 32'h8123_4567);
    // R8: memory word wins over C write to MDR
    step(4'd1, 9'h002, PASS_B, 2'b00, 1'b1, 32'hDEAD_BEEF, 1'b0, 0);
    chk("R8 mem priority", mdr_q, 32'hDEAD_BEEF);

    // random mix
    for (int i = 0; i < 600; i++) begin
      step(4'($urandom), 9'($urandom), 6'($urandom), 2'($urandom),
           ($urandom % 4) == 0, $urandom, ($urandom % 3) == 0, 8'($urandom));
    end
    // R1 again: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    cwe = 9'h1FF;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int k = 0; k < 9; k++) m[k] = 32'h0;
    mm = 8'h0;
    chk("R1 mid reset mar", mar_q, 32'h0);
    chk("R1 mid reset mbr", {24'h0, mbr_q}, 32'h0);
    for (int s = 0; s < 9; s++) step(4'(s), 9'h0, PASS_B, 2'b00, 1'b0, 0, 1'b0, 0);
    step(4'd0, 9'h0, PASS_H, 2'b00, 1'b0, 0, 1'b0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule